// File: doc/BRIEF.md
# Minimum Transition Spacing Enforcer

This block sits after a 64-step interpolator and before the logic that turns position steps into output edges. It compares the incoming 6-bit position code with the position it has released so far and issues single-step moves toward the input, one per transition event. Events never leave closer together than a programmable number of clock cycles. A step that arrives after a quiet period goes straight through at the next clock edge. A burst of steps that arrives too fast, for example from noise on the analog front end, is not dropped. The burst is held as the difference between input and output and released at the minimum spacing until the two codes agree again.

The backlog needs no FIFO. The distance between the input code and the released code, taken modulo 64 along the shorter way round, is the number of events still owed. A separate fast-select input replaces the programmed gap with the smallest gap, for the highest step rate. When the input is exactly half a revolution away from the output, the direction is ambiguous. A sticky error flag is then raised and the output moves upward.

Top module: `step_spacer`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `pos_o` equals `pos_i`, `step_o` is 0 and `amb_err_o` is 0.
- R2: Each cycle with `step_o`=1 shows `pos_o` moved by exactly one code (modulo 64) from the previous cycle. In a cycle with `step_o`=0, `pos_o` is unchanged.
- R3: With `fast_i`=0, two consecutive `step_o` pulses are at least G cycles apart. G is the value of `gap_i` when the earlier step was taken.
- R4: With `fast_i`=1, the spacing is FAST_GAP cycles (default 1), so steps can occur in consecutive cycles.
- R5: When the gap since the last step has elapsed and `pos_i` differs from `pos_o`, `step_o` is 1 in the cycle right after the new `pos_i` is applied. No extra delay is added.
- R6: After an input jump of d codes, the block releases exactly min(d, 64-d) steps and then has `pos_o` equal to `pos_i`. Within a backlog, the steps come exactly G cycles apart.
- R7: For d = (`pos_i` - `pos_o`) mod 64: d in 1..31 steps up (`dir_o`=1, code +1), and d in 33..63 steps down (`dir_o`=0, code -1).
- R8: For d = 32, `amb_err_o` becomes 1 and the step is taken upward. Once set, `amb_err_o` stays at 1 until reset.
- R9: With `fast_i`=0, a `gap_i` value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| pos_i | input | POS_W (6) | Interpolated input position code |
| gap_i | input | GAP_W (8) | Minimum spacing between released steps, in cycles |
| fast_i | input | 1 | Select the smallest spacing (FAST_GAP) instead of `gap_i` |
| pos_o | output | POS_W (6) | Released position code |
| step_o | output | 1 | One-cycle pulse for each released step |
| dir_o | output | 1 | Direction of the last step: 1 up, 0 down |
| amb_err_o | output | 1 | Sticky flag: half-revolution ambiguity was seen |

## Verification
A gap counter that is stuck or reloaded wrongly changes the spacing between `step_o` pulses. This shows up on the second pulse of any burst, at most G cycles after the first. A wrong released position or a wrong direction decision shows up as `pos_o` failing to reach `pos_i`, or as a step count other than the shortest distance, by the end of the burst. A missing latch of the ambiguity state shows up on `amb_err_o` in the cycle after the first half-revolution step. The sweep applies every jump distance from 1 to 63 under several gap settings, so each of these faults appears within one run.

// File: rtl/step_spacer_pkg.sv
package step_spacer_pkg;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } step_dir_e;

   // effective spacing: zero is promoted to one
   function automatic int unsigned eff_gap(input int unsigned raw);
      return (raw == 0) ? 1 : raw;
   endfunction

endpackage

// File: rtl/step_spacer_dist.sv
module step_spacer_dist
   import step_spacer_pkg::*;
#(
   parameter int unsigned POS_W = 6
) (
   input  logic [POS_W-1:0] target_i,
   input  logic [POS_W-1:0] current_i,
   output logic             pending_o,
   output step_dir_e        dir_o,
   output logic             ambig_o
);
   localparam logic [POS_W-1:0] HALF = POS_W'(1) << (POS_W - 1);

   logic [POS_W-1:0] delta;

   always_comb begin
      delta     = target_i - current_i;
      pending_o = (delta != '0);
      ambig_o   = (delta == HALF);
      // half way round resolves upward
      dir_o     = (delta <= HALF) ? DIR_UP : DIR_DOWN;
   end
endmodule

// File: rtl/step_spacer_gap_timer.sv
module step_spacer_gap_timer #(
   parameter int unsigned GAP_W    = 8,
   parameter int unsigned FAST_GAP = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [GAP_W-1:0] gap_i,
   input  logic             fast_i,
   input  logic             load_i,
   output logic             ready_o
);
   logic [GAP_W-1:0] fast_val;
   logic [GAP_W-1:0] slow_val;
   logic [GAP_W-1:0] gap_eff;
   logic [GAP_W-1:0] cnt_q;

   generate
      if (FAST_GAP <= 1) begin : g_fast_unit
         assign fast_val = GAP_W'(1);
      end else begin : g_fast_wide
         assign fast_val = GAP_W'(FAST_GAP);
      end
   endgenerate

   assign slow_val = (gap_i == '0) ? GAP_W'(1) : gap_i;
   assign gap_eff  = fast_i ? fast_val : slow_val;
   assign ready_o  = (cnt_q == '0);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= gap_eff - GAP_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - GAP_W'(1);
      end
   end
endmodule

// File: rtl/step_spacer_track.sv
module step_spacer_track
   import step_spacer_pkg::*;
#(
   parameter int unsigned POS_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [POS_W-1:0] pos_i,
   input  logic             fire_i,
   input  step_dir_e        dir_i,
   input  logic             ambig_i,
   output logic [POS_W-1:0] pos_o,
   output logic             step_o,
   output logic             dir_o,
   output logic             err_o
);
   logic [POS_W-1:0] pos_q;
   logic             step_q;
   logic             dir_q;
   logic             err_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pos_q  <= pos_i;
         step_q <= 1'b0;
         dir_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         step_q <= fire_i;
         if (fire_i) begin
            pos_q <= (dir_i == DIR_UP) ? pos_q + POS_W'(1) : pos_q - POS_W'(1);
            dir_q <= (dir_i == DIR_UP);
            if (ambig_i) err_q <= 1'b1;
         end
      end
   end

   assign pos_o  = pos_q;
   assign step_o = step_q;
   assign dir_o  = dir_q;
   assign err_o  = err_q;
endmodule

// File: rtl/step_spacer.sv
module step_spacer
   import step_spacer_pkg::*;
#(
   parameter int unsigned POS_W    = 6,
   parameter int unsigned GAP_W    = 8,
   parameter int unsigned FAST_GAP = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [POS_W-1:0] pos_i,
   input  logic [GAP_W-1:0] gap_i,
   input  logic             fast_i,
   output logic [POS_W-1:0] pos_o,
   output logic             step_o,
   output logic             dir_o,
   output logic             amb_err_o
);
   generate
      if (POS_W < 2) begin : g_bad_pos_w
         $error("step_spacer: POS_W must be at least 2");
      end
      if (GAP_W < 1) begin : g_bad_gap_w
         $error("step_spacer: GAP_W must be at least 1");
      end
      if (FAST_GAP >= (1 << GAP_W)) begin : g_bad_fast
         $error("step_spacer: FAST_GAP does not fit in GAP_W bits");
      end
   endgenerate

   logic      pending;
   logic      ambig;
   logic      ready;
   logic      fire;
   step_dir_e dir_req;

   step_spacer_dist #(.POS_W(POS_W)) dist_i (
      .target_i  (pos_i),
      .current_i (pos_o),
      .pending_o (pending),
      .dir_o     (dir_req),
      .ambig_o   (ambig)
   );

   step_spacer_gap_timer #(.GAP_W(GAP_W), .FAST_GAP(FAST_GAP)) timer_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .gap_i   (gap_i),
      .fast_i  (fast_i),
      .load_i  (fire),
      .ready_o (ready)
   );

   assign fire = pending & ready;

   step_spacer_track #(.POS_W(POS_W)) track_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pos_i   (pos_i),
      .fire_i  (fire),
      .dir_i   (dir_req),
      .ambig_i (ambig),
      .pos_o   (pos_o),
      .step_o  (step_o),
      .dir_o   (dir_o),
      .err_o   (amb_err_o)
   );
endmodule

// File: rtl/step_spacer_chk.sv
module step_spacer_chk #(
   parameter int unsigned POS_W    = 6,
   parameter int unsigned GAP_W    = 8,
   parameter int unsigned FAST_GAP = 1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [GAP_W-1:0] gap_i,
   input logic             fast_i,
   input logic [POS_W-1:0] pos_o,
   input logic             step_o,
   input logic             dir_o,
   input logic             amb_err_o
);
   localparam int unsigned SW = GAP_W + 2;

   logic [SW-1:0] gap_now;
   logic [SW-1:0] gap_prev_q;
   logic [SW-1:0] lim_q;
   logic [SW-1:0] since_q;

   always_comb begin
      if (fast_i) gap_now = (FAST_GAP <= 1) ? SW'(1) : SW'(FAST_GAP);
      else        gap_now = (gap_i == '0) ? SW'(1) : SW'(gap_i);
   end

   // spacing is decided by the gap present on the cycle before the pulse
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         gap_prev_q <= SW'(1);
         lim_q      <= SW'(1);
         since_q    <= '1;
      end else begin
         gap_prev_q <= gap_now;
         if (step_o) begin
            since_q <= SW'(1);
            lim_q   <= gap_prev_q;
         end else if (since_q != '1) begin
            since_q <= since_q + SW'(1);
         end
      end
   end

   p_reset_quiet_r1: assert property (@(posedge clk_i)
      !rst_ni |=> (!step_o && !amb_err_o));

   p_unit_move_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_o |-> (pos_o == POS_W'($past(pos_o) + POS_W'(1)) ||
                  pos_o == POS_W'($past(pos_o) - POS_W'(1))));

   p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step_o |-> $stable(pos_o));

   p_min_space_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_o |-> (since_q >= lim_q));

   p_dir_up_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_o && dir_o) |-> (pos_o == POS_W'($past(pos_o) + POS_W'(1))));

   p_dir_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_o && !dir_o) |-> (pos_o == POS_W'($past(pos_o) - POS_W'(1))));

   p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      amb_err_o |=> amb_err_o);

   p_err_with_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(amb_err_o) |-> (step_o && dir_o));
endmodule

bind step_spacer step_spacer_chk #(
   .POS_W(POS_W), .GAP_W(GAP_W), .FAST_GAP(FAST_GAP)
) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .gap_i     (gap_i),
   .fast_i    (fast_i),
   .pos_o     (pos_o),
   .step_o    (step_o),
   .dir_o     (dir_o),
   .amb_err_o (amb_err_o)
);

// File: tb/step_spacer_tb.sv
`timescale 1ns/1ps
module step_spacer_tb_top;
   localparam int POS_W = 6;
   localparam int GAP_W = 8;

   logic             clk_i = 1'b0;
   logic             rst_ni = 1'b0;
   logic [POS_W-1:0] pos_i = '0;
   logic [GAP_W-1:0] gap_i = '0;
   logic             fast_i = 1'b0;
   logic [POS_W-1:0] pos_o;
   logic             step_o;
   logic             dir_o;
   logic             amb_err_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2.5 clk_i = ~clk_i;

   step_spacer #(.POS_W(POS_W), .GAP_W(GAP_W), .FAST_GAP(1)) dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .pos_i(pos_i), .gap_i(gap_i),
      .fast_i(fast_i), .pos_o(pos_o), .step_o(step_o), .dir_o(dir_o),
      .amb_err_o(amb_err_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic run_case(input int base, input int delta, input int gap, input bit fast);
      int g, n, steps, first_t, prev_t, bad_sp, bad_mv, tgt;
      bit exp_up;
      logic [POS_W-1:0] prev_pos, exp_pos;
      g      = fast ? 1 : ((gap == 0) ? 1 : gap);
      n      = (delta <= 32) ? delta : 64 - delta;
      exp_up = (delta <= 32);
      tgt    = (base + delta) % 64;
      steps = 0; first_t = -1; prev_t = 0; bad_sp = 0; bad_mv = 0;

      @(negedge clk_i);
      rst_ni = 1'b0; pos_i = POS_W'(base); gap_i = GAP_W'(gap); fast_i = fast;
      @(negedge clk_i);
      @(negedge clk_i);
      // R1 during reset
      chk(pos_o == POS_W'(base) && !step_o && !amb_err_o, "R1 reset", int'(pos_o), base);
      rst_ni = 1'b1;
      @(negedge clk_i);
      // R1 first cycle after release
      chk(pos_o == POS_W'(base) && !step_o && !amb_err_o, "R1 release", int'(pos_o), base);
      prev_pos = pos_o;
      pos_i = POS_W'(tgt);
      for (int t = 1; t <= n * g + 10; t++) begin
         @(negedge clk_i);
         if (step_o) begin
            steps++;
            if (first_t < 0) first_t = t;
            else if (t - prev_t != g) bad_sp++;
            prev_t = t;
            exp_pos = exp_up ? prev_pos + POS_W'(1) : prev_pos - POS_W'(1);
            if (pos_o != exp_pos || dir_o != exp_up) bad_mv++;
         end else if (pos_o != prev_pos) begin
            bad_mv++;
         end
         prev_pos = pos_o;
      end
      chk(steps == n, "R6 step count", steps, n);
      chk(pos_o == POS_W'(tgt), "R6 final position", int'(pos_o), tgt);
      chk(first_t == 1, "R5 first step latency", first_t, 1);
      if (fast)          chk(bad_sp == 0, "R4 fast spacing", bad_sp, 0);
      else if (gap == 0) chk(bad_sp == 0, "R9 zero gap spacing", bad_sp, 0);
      else               chk(bad_sp == 0, "R3 spacing", bad_sp, 0);
      chk(bad_mv == 0, "R2 R7 unit move and direction", bad_mv, 0);
      chk(amb_err_o == (delta == 32), "R8 ambiguity flag", int'(amb_err_o), int'(delta == 32));
   endtask

   // R5: after a quiet period a single step passes at once; R8 flag stays sticky
   task automatic idle_then_step();
      int t_step;
      run_case(10, 32, 3, 0);
      repeat (6) @(negedge clk_i);
      pos_i = pos_i - POS_W'(1);
      t_step = -1;
      for (int t = 1; t <= 4; t++) begin
         @(negedge clk_i);
         if (step_o && t_step < 0) t_step = t;
      end
      chk(t_step == 1, "R5 isolated step latency", t_step, 1);
      chk(dir_o == 1'b0, "R7 down after idle", int'(dir_o), 0);
      chk(amb_err_o == 1'b1, "R8 flag held", int'(amb_err_o), 1);
   endtask

   initial begin
      int gaps[4] = '{0, 2, 5, 5};
      bit fasts[4] = '{0, 0, 0, 1};
      repeat (3) @(negedge clk_i);
      for (int c = 0; c < 4; c++) begin
         for (int d = 1; d < 64; d++) begin
            run_case((d * 7) % 64, d, gaps[c], fasts[c]);
         end
      end
      idle_then_step();
      summary();
   end

   initial begin
      #(200000 * 5);
      chk(1'b0, "watchdog", 0, 1);
      summary();
   end
endmodule